// File: doc/BRIEF.md
# Twice-Prime Folding Reducer for 512-bit Products

This block takes a 512-bit product, the output of a 256x256-bit multiplication held as sixteen 32-bit words, and returns a 256-bit value congruent to it modulo M = 2^256 - 38. M is twice the 255-bit prime used by a common Montgomery-curve key agreement. Keeping field elements reduced only modulo M is enough for every multiplication in a long chain. The block contains no multiplier. The factor 38 (from 2^256 ≡ 38 mod M) is applied as the sum of copies shifted left by 5, 2 and 1 bits.

The work is word-serial. A first fold adds 38 times the upper half into the lower half, one word per cycle, through a three-register pipeline of four adders. This gives a nine-word intermediate of at most 262 bits. A second fold multiplies the small ninth word by 38 (again by shifts), adds it at word 0 and ripples the carry up. The result is a 257-bit value that cannot reach 2M. In the same pass the block subtracts M word by word. The sign of the last borrow then picks between the two candidates. Because the intermediate is below 2M, the returned value is always below M.

A caller pulses `start_i` while the block is idle, with the product on `prod_i`. It then waits for the single-cycle `done_o` pulse, after which `result_o` holds the reduced value.

Top module: `fr_reduce_2p`

## Requirements
- R1: A cycle with `start_i` high while `busy_o` is low captures `prod_i`, and `busy_o` is high from the next cycle until the cycle in which `done_o` is high.
- R2: At the `done_o` pulse, `result_o` equals the captured product modulo M = 2^256 - 38, and is therefore strictly below M.
- R3: `done_o` is high for exactly one cycle, 2*NW+4 = 20 clock edges after the edge that accepted `start_i`, and `busy_o` is low in that same cycle.
- R4: `start_i` raised while `busy_o` is high is ignored: neither the running computation, its timing nor its result changes.
- R5: `result_o` keeps its value in every cycle between `done_o` pulses.
- R6: The all-ones 512-bit input, which gives the largest carries in both folds, reduces to (2^512 - 1) mod M.
- R7: Inputs at the subtraction boundary reduce correctly: M itself gives 0, M - 1 comes back unchanged, a lower half in [M, 2^256) with a zero upper half comes back less M, and 2^256 gives 38.
- R8: While synchronous reset is high, `busy_o`, `done_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to reduce `prod_i`, taken only when idle |
| prod_i | input | 512 | Product to reduce; word k is bits 32k+31..32k |
| busy_o | output | 1 | High while a reduction is in progress |
| done_o | output | 1 | One-cycle pulse marking a fresh `result_o` |
| result_o | output | 256 | Reduced value, below 2^256 - 38 |

## Verification
The hardest case to reach is the one where the second fold carries past bit 255, so that the nine-word intermediate has a nonzero top word and the final borrow must come out clear. Random products almost never land in the band between M and 2^256. The stimulus therefore places values there directly: a lower half of all ones, the modulus itself, one below it, and the all-ones product whose two folds both carry at full width. These are mixed with random products and with a start request raised in the middle of a busy run. A behavioural model predicts `busy_o`, `done_o` and `result_o` for every cycle.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int unsigned FR_W  = 32;  // datapath word width
  localparam int unsigned FR_NW = 8;   // words in one 256-bit half

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FOLD1 = 2'd1,
    ST_FOLD2 = 2'd2
  } fr_state_e;

  // 38 = 2^5 + 2^2 + 2^1 : left-shift amounts of the three copies
  function automatic int unsigned fr_shift_amt(input int unsigned sel);
    case (sel)
      0:       return 1;
      1:       return 2;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/fr_fold38_pipe.sv
// First fold: per word step, low + (hi<<1) + (hi<<2) + (hi<<5) + carry,
// through a three-register pipeline of four adders.
module fr_fold38_pipe #(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic         in_first,
  input  logic [W-1:0] hi_cur,
  input  logic [W-1:0] hi_prev,
  input  logic [W-1:0] lo_cur,
  output logic         out_vld,
  output logic [W-1:0] out_word
);
  localparam int unsigned EW = W + CW;

  logic [W-1:0] sh [3];
  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_shift
      localparam int unsigned SA = fr_pkg::fr_shift_amt(g);
      assign sh[g] = (hi_cur << SA) | (hi_prev >> (W - SA));
    end
  endgenerate

  logic [W:0]    t1_q, t2_q;
  logic [W+1:0]  t3_q;
  logic          v1_q, f1_q, v2_q, f2_q;
  logic [CW-1:0] carry_q;
  logic [EW-1:0] t4;

  always_ff @(posedge clk) begin
    if (rst) begin
      t1_q <= '0; t2_q <= '0; t3_q <= '0;
      v1_q <= 1'b0; f1_q <= 1'b0; v2_q <= 1'b0; f2_q <= 1'b0;
      carry_q <= '0;
    end else begin
      t1_q <= {1'b0, sh[0]} + {1'b0, sh[1]};
      t2_q <= {1'b0, sh[2]} + {1'b0, lo_cur};
      v1_q <= in_vld;
      f1_q <= in_first;
      t3_q <= {1'b0, t1_q} + {1'b0, t2_q};
      v2_q <= v1_q;
      f2_q <= f1_q;
      if (v2_q) carry_q <= t4[EW-1:W];
    end
  end

  assign t4       = EW'(t3_q) + (f2_q ? '0 : EW'(carry_q));
  assign out_vld  = v2_q;
  assign out_word = t4[W-1:0];
endmodule

// File: rtl/fr_s1_store.sv
// Holds the low words of the first-fold result until the second fold.
module fr_s1_store #(
  parameter int unsigned W  = 32,
  parameter int unsigned NW = 8,
  localparam int unsigned AW = $clog2(NW)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [NW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fr_fold2_sub.sv
// Second fold (38 * top word into word 0, carry ripple) with the trial
// subtraction of the modulus running in the same word step.
module fr_fold2_sub #(
  parameter int unsigned W    = 32,
  parameter int unsigned NW   = 8,
  parameter int unsigned CNTW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init_i,
  input  logic [W-1:0]    top_i,
  input  logic            step_i,
  input  logic [CNTW-1:0] idx_i,
  input  logic [W-1:0]    y_i,
  output logic [NW*W-1:0] keep_sum_o,
  output logic [NW*W-1:0] keep_dif_o,
  output logic            bor_next_o
);
  logic [W-1:0] carry_q;
  logic         bor_q;
  logic [W:0]   sum;
  logic [W:0]   dif;
  logic [W-1:0] nword;

  always_comb begin
    if (idx_i == '0)               nword = {W{1'b1}} - W'(37);
    else if (idx_i < CNTW'(NW))    nword = {W{1'b1}};
    else                           nword = '0;
  end

  assign sum = {1'b0, carry_q} + {1'b0, y_i};
  assign dif = {1'b0, sum[W-1:0]} - {1'b0, nword} - (W+1)'(bor_q);
  assign bor_next_o = dif[W];

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= '0;
      bor_q   <= 1'b0;
    end else if (init_i) begin
      carry_q <= (top_i << 1) + (top_i << 2) + (top_i << 5);
      bor_q   <= 1'b0;
    end else if (step_i) begin
      carry_q <= W'(sum[W]);
      bor_q   <= dif[W];
    end
  end

  genvar k;
  generate
    for (k = 0; k < NW; k++) begin : g_keep
      always_ff @(posedge clk) begin
        if (rst) begin
          keep_sum_o[k*W +: W] <= '0;
          keep_dif_o[k*W +: W] <= '0;
        end else if (step_i && idx_i == CNTW'(k)) begin
          keep_sum_o[k*W +: W] <= sum[W-1:0];
          keep_dif_o[k*W +: W] <= dif[W-1:0];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/fr_reduce_2p.sv
module fr_reduce_2p #(
  parameter int unsigned W  = fr_pkg::FR_W,
  parameter int unsigned NW = fr_pkg::FR_NW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [2*NW*W-1:0] prod_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [NW*W-1:0]   result_o
);
  import fr_pkg::*;
  localparam int unsigned CNTW = $clog2(NW + 2);
  localparam int unsigned AW   = $clog2(NW);

  fr_state_e         state_q;
  logic [2*NW*W-1:0] in_q;
  logic [CNTW-1:0]   feed_q, wr_q, step_q;
  logic [W-1:0]      hi_cur, hi_prev, lo_cur;
  logic              feed_vld, s1_vld, last_s1, f2_step, bor_fin;
  logic [W-1:0]      s1_word, s1_rd, y_word;
  logic [NW*W-1:0]   keep_sum, keep_dif;

  always_comb begin
    hi_cur = '0; hi_prev = '0; lo_cur = '0;
    for (int k = 0; k < NW; k++) begin
      if (feed_q == CNTW'(k)) begin
        hi_cur = in_q[(NW+k)*W +: W];
        lo_cur = in_q[k*W +: W];
      end
      if (feed_q == CNTW'(k+1)) hi_prev = in_q[(NW+k)*W +: W];
    end
  end

  assign feed_vld = (state_q == ST_FOLD1) && (feed_q <= CNTW'(NW));
  assign last_s1  = s1_vld && (wr_q == CNTW'(NW));
  assign f2_step  = (state_q == ST_FOLD2);
  assign y_word   = (step_q < CNTW'(NW)) ? s1_rd : '0;

  fr_fold38_pipe #(.W(W), .CW(8)) u_fold1 (
    .clk(clk), .rst(rst), .in_vld(feed_vld), .in_first(feed_q == '0),
    .hi_cur(hi_cur), .hi_prev(hi_prev), .lo_cur(lo_cur),
    .out_vld(s1_vld), .out_word(s1_word)
  );

  fr_s1_store #(.W(W), .NW(NW)) u_store (
    .clk(clk), .we(s1_vld && !last_s1), .waddr(wr_q[AW-1:0]),
    .wdata(s1_word), .raddr(step_q[AW-1:0]), .rdata(s1_rd)
  );

  fr_fold2_sub #(.W(W), .NW(NW), .CNTW(CNTW)) u_fold2 (
    .clk(clk), .rst(rst), .init_i(last_s1), .top_i(s1_word),
    .step_i(f2_step), .idx_i(step_q), .y_i(y_word),
    .keep_sum_o(keep_sum), .keep_dif_o(keep_dif), .bor_next_o(bor_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      in_q <= '0; feed_q <= '0; wr_q <= '0; step_q <= '0;
      busy_o <= 1'b0; done_o <= 1'b0; result_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          in_q    <= prod_i;
          feed_q  <= '0;
          wr_q    <= '0;
          busy_o  <= 1'b1;
          state_q <= ST_FOLD1;
        end
        ST_FOLD1: begin
          if (feed_vld) feed_q <= feed_q + 1'b1;
          if (last_s1) begin
            step_q  <= '0;
            state_q <= ST_FOLD2;
          end else if (s1_vld) begin
            wr_q <= wr_q + 1'b1;
          end
        end
        ST_FOLD2: begin
          step_q <= step_q + 1'b1;
          if (step_q == CNTW'(NW)) begin
            result_o <= bor_fin ? keep_sum : keep_dif;
            done_o   <= 1'b1;
            busy_o   <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fr_reduce_chk.sv
module fr_reduce_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned NW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [NW*W-1:0] result_o
);
  localparam int unsigned   LAT = 2*NW + 4;
  localparam logic [NW*W-1:0] MODV = {(NW*W){1'b1}} - (NW*W)'(37);

  int unsigned since_start;
  always_ff @(posedge clk) begin
    if (rst)                    since_start <= 0;
    else if (start_i && !busy_o) since_start <= 0;
    else if (busy_o)            since_start <= since_start + 1;
  end

  a_r1_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);
  a_r2_below_modulus: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (result_o < MODV));
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r3_done_clears_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (since_start == LAT));
  a_r5_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));
endmodule

bind fr_reduce_2p fr_reduce_chk #(.W(W), .NW(NW)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .result_o(result_o)
);

// File: tb/fr_reduce_2p_tb.sv
module fr_reduce_2p_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NW = 8;
  localparam int LAT = 2*NW + 4;
  localparam logic [255:0] MODV = {256{1'b1}} - 256'd37;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [511:0] prod_i = '0;
  logic         busy_o, done_o;
  logic [255:0] result_o;

  fr_reduce_2p #(.W(W), .NW(NW)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .prod_i(prod_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    vectors = 0;
  int    miscompares = 0;
  int    cyc = 0;
  string cur_tag = "reset";

  // behavioural reference model
  logic         m_busy = 1'b0, m_done = 1'b0;
  int           m_cnt = 0;
  logic [255:0] m_exp = '0, m_res = '0;

  function automatic logic [255:0] ref_mod(input logic [511:0] x);
    logic [511:0] r;
    r = x % {256'd0, MODV};
    return r[255:0];
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_res = '0;
    end else begin
      m_done = 0;
      if (!m_busy && start_i) begin
        m_busy = 1; m_cnt = 0; m_exp = ref_mod(prod_i);
      end else if (m_busy) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == LAT) begin
          m_busy = 0; m_done = 1; m_res = m_exp;
        end
      end
    end
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected end before 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cyc > 0) begin
      vectors++;
      if (rst) begin
        // R8: reset state
        if (busy_o !== 1'b0 || done_o !== 1'b0 || result_o !== '0) begin
          miscompares++;
          $display("FAIL R8 reset: actual busy=%b done=%b res=%h expected 0 0 0",
                   busy_o, done_o, result_o);
        end
      end else begin
        if (busy_o !== m_busy) begin
          miscompares++;
          $display("FAIL R1 [%s] busy: actual %b expected %b", cur_tag, busy_o, m_busy);
        end
        if (done_o !== m_done) begin
          miscompares++;
          $display("FAIL R3 [%s] done: actual %b expected %b", cur_tag, done_o, m_done);
        end
        if (result_o !== m_res) begin
          miscompares++;
          if (m_done)
            $display("FAIL R2 [%s] result: actual %h expected %h", cur_tag, result_o, m_res);
          else
            $display("FAIL R5 [%s] held result: actual %h expected %h", cur_tag, result_o, m_res);
        end
      end
    end
  end

  task automatic run_one(input logic [511:0] x, input string tag);
    @(posedge clk);
    while (m_busy) @(posedge clk);
    #1;
    cur_tag = tag;
    prod_i  = x;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    prod_i  = '0;
    @(negedge clk);
    while (!m_done) @(negedge clk);
  endtask

  // R4: a second request during a busy run must be ignored
  task automatic run_with_intrusion(input logic [511:0] x, input logic [511:0] y);
    @(posedge clk);
    while (m_busy) @(posedge clk);
    #1;
    cur_tag = "R4 intrusion";
    prod_i  = x;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    prod_i  = y;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    prod_i  = '0;
    @(negedge clk);
    while (!m_done) @(negedge clk);
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R7 boundary values around the modulus
    run_one(512'd0, "R7 zero");
    run_one({256'd0, MODV}, "R7 equal M");
    run_one({256'd0, MODV - 256'd1}, "R7 M-1");
    run_one({256'd0, {256{1'b1}}}, "R7 low in [M,2^256)");
    run_one({256'd1, 256'd0}, "R7 2^256");
    run_one({256'd0, MODV + 256'd20}, "R7 M+20");
    // R6 maximum input and other full-width patterns
    run_one({512{1'b1}}, "R6 all ones");
    run_one({{256{1'b1}}, 256'd0}, "R6 high ones");
    run_one({MODV, MODV}, "R6 both halves M");
    // R2 random products
    for (int n = 0; n < 40; n++) run_one(rnd512(), "R2 random");
    // R4 ignored start while busy
    run_with_intrusion(rnd512(), {512{1'b1}});
    // R5 idle hold after a result
    repeat (10) @(posedge clk);
    run_one(rnd512(), "R2 after idle");
    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule